// File: doc/BRIEF.md
# Floppy Adaptor Output Register Controller

This block holds the one-byte, write-only control register that a floppy adaptor exposes to the host. The byte carries a two-bit drive select, a run line that keeps the disk controller out of reset, an interrupt enable and one motor enable per drive. The block turns each host write into the side effects a disk controller sequencer relies on. It produces a one-cycle controller reset pulse and per-drive motor start and stop pulses. It keeps an internal interrupt line and a gated interrupt request for the system interrupt controller. It records the drive last selected together with a low-numbered motor. It holds four pending sense-status slots, which it preloads each time the controller leaves reset.

A write is a single-cycle strobe (`wr_en` with `wr_data`). Every output is registered, so the effects of a write appear in the cycle after the edge that takes it. Pulses last exactly one cycle. The command sequencer lowers the interrupt with `clr_int` and retires sense slots with `slot_clr`. All of these are plain control pins: no data stream passes through the block, so it has no valid/ready handshake.

Top module: `fdd_outreg_ctrl`

## Requirements
- R1: After reset, the stored byte, the interrupt line, the interrupt request, the last-used drive, every slot-full flag and every pulse output are 0.
- R2: The stored byte uses these bit positions: bits 1:0 drive select, bit 2 run (controller out of reset), bit 3 interrupt enable, and bits 4..7 the motor enables of drives 0..3. A write with bit 2 = 1 stores the whole byte, which is visible on `reg_value` in the next cycle.
- R3: A write with bit 2 = 0 stores the byte with bits 7:4 forced to 0. It emits a one-cycle `rqm_clr_pulse` and clears the interrupt line. It emits no motor pulses and leaves the last-used drive unchanged.
- R4: A write that changes bit 2 from 0 to 1 emits `ctl_reset_pulse` for exactly one cycle and sets the interrupt line. It also marks all four slots full, with first byte 0xC0 + i and second byte 0x00 for slot i.
- R5: The interrupt request rises on a write where bit 2 goes 0 to 1 and the new bit 3 is 1. It also rises on a write with bit 2 = 1 where bit 3 goes 0 to 1 while the interrupt line is already high. No other event raises it.
- R6: The interrupt request stays high until `clr_int`, which clears both the request and the interrupt line. A raise or line set in the same cycle takes priority over `clr_int`.
- R7: On a write with bit 2 = 1, each motor bit that goes 0 to 1 gives a one-cycle `motor_on_pulse` for that drive. Each motor bit that goes 1 to 0 gives a one-cycle `motor_off_pulse`.
- R8: `last_drive` takes the written drive select only on a write with bit 2 = 1 whose motor 0 or motor 1 bit is 1. Otherwise it holds its value.
- R9: `slot_clr[i]` clears slot i's full flag. When a preload (R4) happens in the same cycle, the preload wins.
- R10: A write with bit 2 = 1 while bit 2 is already 1 produces no reset pulse and does not reload the slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe for the register |
| wr_data | input | 8 | Byte written with `wr_en` |
| clr_int | input | 1 | Sequencer strobe clearing interrupt line and request |
| slot_clr | input | 4 | Per-slot strobe retiring a pending sense result |
| reg_value | output | 8 | Stored register byte |
| ctl_reset_pulse | output | 1 | One-cycle controller reset on leaving reset |
| rqm_clr_pulse | output | 1 | One-cycle request to drop the controller's ready flag |
| motor_on_pulse | output | 4 | Per-drive motor start pulses |
| motor_off_pulse | output | 4 | Per-drive motor stop pulses |
| int_line | output | 1 | Internal controller interrupt line |
| irq | output | 1 | Gated interrupt request to the system interrupt controller |
| last_drive | output | 2 | Drive last selected with motor 0 or 1 on |
| slot_full | output | 4 | Pending flag per sense slot |
| slot_st0 | output | 32 | First result byte per slot, slot i at bits 8i+7:8i |
| slot_pcn | output | 32 | Second result byte per slot, slot i at bits 8i+7:8i |

## Verification
The assertions assume that reset is held low for at least one edge before any write. They also assume that `wr_en`, `clr_int` and `slot_clr` are sampled only at rising edges, with no further conditions: any combination of these inputs may arrive in the same cycle. The stimulus changes every input at the falling edge and holds it through exactly one rising edge. It deliberately combines a write with `clr_int`, and a preloading write with `slot_clr`, so that the priority rules are exercised within these assumptions.

// File: rtl/fdo_pkg.sv
package fdo_pkg;
  localparam int NDRV   = 4;
  localparam int SEL_W  = $clog2(NDRV);
  localparam int BYTE_W = 8;

  // packed MSB first: motors in 7:4, enable 3, run 2, select 1:0
  typedef struct packed {
    logic [NDRV-1:0]  motor;
    logic             ien;
    logic             run;
    logic [SEL_W-1:0] sel;
  } outreg_t;

  // image kept when the controller is held in reset
  function automatic outreg_t held_image(outreg_t v);
    outreg_t r;
    r       = v;
    r.motor = '0;
    return r;
  endfunction
endpackage

// File: rtl/fdo_field_reg.sv
module fdo_field_reg
  import fdo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  outreg_t          wr_val,
  output outreg_t          cur,
  output logic             exit_rst,
  output logic             hold_wr,
  output logic             live_wr,
  output logic             ien_rise,
  output logic             reset_pulse,
  output logic             rqm_clr_pulse,
  output logic [SEL_W-1:0] last_drive
);
  logic low_motor_on;

  always_comb begin
    hold_wr      = wr_en & ~wr_val.run;
    live_wr      = wr_en & wr_val.run;
    exit_rst     = live_wr & ~cur.run;
    ien_rise     = live_wr & wr_val.ien & ~cur.ien;
    low_motor_on = wr_val.motor[0] | wr_val.motor[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur           <= '0;
      reset_pulse   <= 1'b0;
      rqm_clr_pulse <= 1'b0;
      last_drive    <= '0;
    end else begin
      reset_pulse   <= exit_rst;
      rqm_clr_pulse <= hold_wr;
      if (hold_wr)
        cur <= held_image(wr_val);
      else if (live_wr)
        cur <= wr_val;
      if (live_wr && low_motor_on)
        last_drive <= wr_val.sel;
    end
  end

  a_r2_store_live: assert property (@(posedge clk) disable iff (!rst_n)
    live_wr |=> cur == $past(wr_val));
  a_r3_motors_forced: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr |=> cur.motor == '0);
  a_r4_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |=> !reset_pulse);
  a_r8_drive_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(live_wr && low_motor_on) |=> $stable(last_drive));
endmodule

// File: rtl/fdo_irq_ctl.sv
module fdo_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_wr,
  input  logic exit_rst,
  input  logic ien_rise,
  input  logic new_ien,
  input  logic clr_int,
  output logic int_line,
  output logic irq
);
  logic raise;

  always_comb raise = (exit_rst & new_ien) | (ien_rise & int_line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_line <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (hold_wr)
        int_line <= 1'b0;
      else if (exit_rst)
        int_line <= 1'b1;
      else if (clr_int)
        int_line <= 1'b0;

      if (raise)
        irq <= 1'b1;
      else if (clr_int)
        irq <= 1'b0;
    end
  end

  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_int && !raise) |=> !irq);
  a_r3_line_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr |=> !int_line);
  a_r4_line_set: assert property (@(posedge clk) disable iff (!rst_n)
    exit_rst |=> int_line);
endmodule

// File: rtl/fdo_motor_edges.sv
module fdo_motor_edges #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         live_wr,
  input  logic [N-1:0] old_m,
  input  logic [N-1:0] new_m,
  output logic [N-1:0] on_p,
  output logic [N-1:0] off_p
);
  for (genvar i = 0; i < N; i++) begin : g_drv
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        on_p[i]  <= 1'b0;
        off_p[i] <= 1'b0;
      end else begin
        on_p[i]  <= live_wr & new_m[i] & ~old_m[i];
        off_p[i] <= live_wr & old_m[i] & ~new_m[i];
      end
    end

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(on_p[i] && off_p[i]));
  end
endmodule

// File: rtl/fdo_slot_bank.sv
module fdo_slot_bank #(
  parameter int       N    = 4,
  parameter int       BW   = 8,
  parameter bit [7:0] BASE = 8'hC0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [N-1:0]  clr,
  output logic [N-1:0]  full,
  output logic [N*BW-1:0] st0,
  output logic [N*BW-1:0] pcn
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    localparam logic [BW-1:0] CODE = BW'(BASE) + BW'(i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full[i]          <= 1'b0;
        st0[i*BW +: BW]  <= '0;
        pcn[i*BW +: BW]  <= '0;
      end else if (load) begin
        full[i]          <= 1'b1;
        st0[i*BW +: BW]  <= CODE;
        pcn[i*BW +: BW]  <= '0;
      end else if (clr[i]) begin
        full[i]          <= 1'b0;
      end
    end

    a_r9_clear_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !load) |=> !full[i]);
  end

  a_r4_load_all: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> &full);
endmodule

// File: rtl/fdd_outreg_ctrl.sv
module fdd_outreg_ctrl
  import fdo_pkg::*;
#(
  parameter bit [7:0] SLOT_CODE_BASE = 8'hC0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [BYTE_W-1:0]    wr_data,
  input  logic                 clr_int,
  input  logic [NDRV-1:0]      slot_clr,
  output logic [BYTE_W-1:0]    reg_value,
  output logic                 ctl_reset_pulse,
  output logic                 rqm_clr_pulse,
  output logic [NDRV-1:0]      motor_on_pulse,
  output logic [NDRV-1:0]      motor_off_pulse,
  output logic                 int_line,
  output logic                 irq,
  output logic [SEL_W-1:0]     last_drive,
  output logic [NDRV-1:0]      slot_full,
  output logic [NDRV*BYTE_W-1:0] slot_st0,
  output logic [NDRV*BYTE_W-1:0] slot_pcn
);
  outreg_t wr_val, cur;
  logic    exit_rst, hold_wr, live_wr, ien_rise;

  assign wr_val    = outreg_t'(wr_data);
  assign reg_value = cur;

  fdo_field_reg u_field (
    .clk, .rst_n, .wr_en, .wr_val, .cur,
    .exit_rst, .hold_wr, .live_wr, .ien_rise,
    .reset_pulse(ctl_reset_pulse), .rqm_clr_pulse, .last_drive
  );

  fdo_irq_ctl u_irq (
    .clk, .rst_n, .hold_wr, .exit_rst, .ien_rise,
    .new_ien(wr_val.ien), .clr_int, .int_line, .irq
  );

  fdo_motor_edges #(.N(NDRV)) u_motor (
    .clk, .rst_n, .live_wr,
    .old_m(cur.motor), .new_m(wr_val.motor),
    .on_p(motor_on_pulse), .off_p(motor_off_pulse)
  );

  fdo_slot_bank #(.N(NDRV), .BW(BYTE_W), .BASE(SLOT_CODE_BASE)) u_slots (
    .clk, .rst_n, .load(exit_rst), .clr(slot_clr),
    .full(slot_full), .st0(slot_st0), .pcn(slot_pcn)
  );

  // cross-block checks
  a_r4_pulse_with_slots: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset_pulse |-> (&slot_full) && int_line && reg_value[2]);
  a_r3_hold_effects: assert property (@(posedge clk) disable iff (!rst_n)
    rqm_clr_pulse |-> !reg_value[2] && !int_line && motor_on_pulse == '0 && motor_off_pulse == '0);
  a_r5_irq_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wr_en) && reg_value[2] && reg_value[3]);

  for (genvar d = 0; d < NDRV; d++) begin : g_mchk
    a_r7_on_matches: assert property (@(posedge clk) disable iff (!rst_n)
      motor_on_pulse[d] |-> reg_value[4+d] && !$past(reg_value[4+d]));
    a_r7_off_matches: assert property (@(posedge clk) disable iff (!rst_n)
      motor_off_pulse[d] |-> !reg_value[4+d] && $past(reg_value[4+d]));
  end
endmodule

// File: tb/tb_fdd_outreg_ctrl.sv
module tb_fdd_outreg_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        clr_int = 1'b0;
  logic [3:0]  slot_clr = '0;
  logic [7:0]  reg_value;
  logic        ctl_reset_pulse, rqm_clr_pulse, int_line, irq;
  logic [3:0]  motor_on_pulse, motor_off_pulse, slot_full;
  logic [1:0]  last_drive;
  logic [31:0] slot_st0, slot_pcn;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fdd_outreg_ctrl dut (
    .clk, .rst_n, .wr_en, .wr_data, .clr_int, .slot_clr,
    .reg_value, .ctl_reset_pulse, .rqm_clr_pulse,
    .motor_on_pulse, .motor_off_pulse, .int_line, .irq,
    .last_drive, .slot_full, .slot_st0, .slot_pcn
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus, then settle just after the edge
  task automatic step(bit w, logic [7:0] d, bit c, logic [3:0] s);
    @(negedge clk);
    wr_en = w; wr_data = d; clr_int = c; slot_clr = s;
    @(posedge clk);
    #1;
    wr_en = 1'b0; clr_int = 1'b0; slot_clr = '0;
  endtask

  task automatic t_reset();
    check("R1", "reg", reg_value, 0);
    check("R1", "int_line", int_line, 0);
    check("R1", "irq", irq, 0);
    check("R1", "last_drive", last_drive, 0);
    check("R1", "slot_full", slot_full, 0);
    check("R1", "pulses", {ctl_reset_pulse, rqm_clr_pulse, motor_on_pulse, motor_off_pulse}, 0);
  endtask

  task automatic t_hold_write();
    step(1, 8'hF9, 0, 0);
    check("R3", "reg motors forced", reg_value, 8'h09);
    check("R3", "rqm pulse", rqm_clr_pulse, 1);
    check("R3", "no motor pulses", {motor_on_pulse, motor_off_pulse}, 0);
    check("R3", "last_drive held", last_drive, 0);
    check("R3", "int_line", int_line, 0);
    step(0, 8'h00, 0, 0);
    check("R3", "rqm pulse one cycle", rqm_clr_pulse, 0);
  endtask

  task automatic t_leave_reset();
    step(1, 8'h1C, 0, 0);
    check("R2", "reg stored", reg_value, 8'h1C);
    check("R4", "reset pulse", ctl_reset_pulse, 1);
    check("R4", "int_line set", int_line, 1);
    check("R4", "slots full", slot_full, 4'hF);
    check("R4", "slot first bytes", slot_st0, 32'hC3C2C1C0);
    check("R4", "slot second bytes", slot_pcn, 0);
    check("R5", "irq on run rise with enable", irq, 1);
    check("R7", "motor0 on", motor_on_pulse, 4'b0001);
    step(0, 8'h00, 0, 0);
    check("R4", "reset pulse one cycle", ctl_reset_pulse, 0);
    check("R7", "on pulse one cycle", motor_on_pulse, 0);
  endtask

  task automatic t_clear();
    step(0, 8'h00, 1, 0);
    check("R6", "irq cleared", irq, 0);
    check("R6", "line cleared", int_line, 0);
  endtask

  task automatic t_enable_paths();
    step(1, 8'h00, 0, 0);
    check("R3", "hold write no off pulse", motor_off_pulse, 0);
    step(1, 8'h04, 0, 0);
    check("R4", "line set without enable", int_line, 1);
    check("R5", "no irq without enable", irq, 0);
    step(1, 8'h0C, 0, 0);
    check("R5", "irq on enable rise with line high", irq, 1);
    check("R10", "no reset pulse run held", ctl_reset_pulse, 0);
    step(0, 8'h00, 1, 0);
    check("R6", "irq cleared again", irq, 0);
    step(1, 8'h04, 0, 0);
    step(1, 8'h0C, 0, 0);
    check("R5", "no irq enable rise with line low", irq, 0);
    check("R10", "slots not reloaded", slot_full, 4'hF);
  endtask

  task automatic t_motors();
    step(1, 8'h36, 0, 0);
    check("R7", "on drives 0,1", motor_on_pulse, 4'b0011);
    check("R8", "last drive 2", last_drive, 2);
    step(1, 8'hC7, 0, 0);
    check("R7", "on drives 2,3", motor_on_pulse, 4'b1100);
    check("R7", "off drives 0,1", motor_off_pulse, 4'b0011);
    check("R8", "last drive held w/o motor0/1", last_drive, 2);
    step(1, 8'h57, 0, 0);
    check("R7", "on drive 0", motor_on_pulse, 4'b0001);
    check("R7", "off drive 3", motor_off_pulse, 4'b1000);
    check("R8", "last drive 3", last_drive, 3);
    step(1, 8'h02, 0, 0);
    check("R3", "hold write with motors on", motor_off_pulse, 0);
    check("R8", "hold write keeps last drive", last_drive, 3);
  endtask

  task automatic t_slots();
    step(1, 8'h04, 0, 0);
    check("R9", "reload", slot_full, 4'hF);
    step(0, 8'h00, 0, 4'b0101);
    check("R9", "slots retired", slot_full, 4'b1010);
    step(1, 8'h00, 0, 0);
    check("R9", "hold write keeps slots", slot_full, 4'b1010);
    step(1, 8'h04, 0, 4'b1111);
    check("R9", "preload beats clear", slot_full, 4'hF);
  endtask

  task automatic t_race();
    step(1, 8'h00, 0, 0);
    step(1, 8'h0C, 1, 0);
    check("R6", "raise beats clear irq", irq, 1);
    check("R6", "set beats clear line", int_line, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_hold_write();
    t_leave_reset();
    t_clear();
    t_enable_paths();
    t_motors();
    t_slots();
    t_race();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule